// File: doc/BRIEF.md
# Enable and Sync Control-Pin Decoder

One control pin does three jobs. Held high, it enables the converters. Toggling, it enables them and also supplies the switching clock. Held low for long enough, it shuts them down. The block samples the pin with a fast free-running reference clock, passes it through a synchroniser, and finds its edges. A retriggerable one-shot raises a clock-detect flag for as long as edges keep arriving. That flag holds the enable output up and picks the external pin as the switching source. Without the flag, the source is an internal oscillator tick that arrives as a one-cycle pulse in the reference domain.

The selected source drives a divide-by-two stage. Its two outputs are phase enables for two converters. They run at half the rate of the selected source and are always in antiphase. A change of source waits for a point where the divider can restart cleanly at phase A, so no phase pulse is cut short or doubled. Both timeouts are reference-clock cycle counts. The defaults of 200 cycles give 4 µs at a 50 MHz reference. An external clock from 1.5 MHz to 3 MHz is therefore well inside the detection window. A pin level has to last at least one reference cycle to be seen.

Top module: `ctl_pin_decoder`

## Requirements
- R1: After reset, `enable_o`, `clk_det_o`, `src_ext_o`, `phase_a_o` and `phase_b_o` are all 0, and the divider stands at phase A.
- R2: The pin passes through SYNC_STAGES flops before any use. A synchronised high level sets `enable_o` on the next reference edge.
- R3: `enable_o` clears once the synchronised pin has been low for LOW_CYCLES consecutive samples while `clk_det_o` is 0. A low run that is shorter leaves `enable_o` high.
- R4: Every synchronised edge, rising or falling, reloads the one-shot. `clk_det_o` stays 1 for exactly HOLD_CYCLES cycles after the last edge and then falls.
- R5: While `clk_det_o` is 1, `enable_o` is held at 1, even if the pin is currently low.
- R6: While enabled, `src_ext_o` (1 = external pin, 0 = internal tick) follows `clk_det_o`, but only at an internal tick. The move from internal to external waits for an internal tick that finds the divider in phase B. The move from external to internal takes the first internal tick. In both cases the divider restarts at phase A.
- R7: While enabled and no source change is taken, the divider toggles on each tick of the selected source and holds otherwise. A tick of the external source is a synchronised rising edge; a tick of the internal source is an `osc_tick` pulse. Each phase output therefore runs at half the selected rate.
- R8: While `enable_o` is 1, exactly one of `phase_a_o` and `phase_b_o` is 1.
- R9: While `enable_o` is 0, both phase outputs are 0, the divider is held at phase A, and `src_ext_o` copies `clk_det_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin | input | 1 | Asynchronous dual-purpose control pin |
| osc_tick | input | 1 | One-cycle pulse from the internal oscillator |
| enable_o | output | 1 | Converter enable |
| clk_det_o | output | 1 | Pin toggling detected (one-shot active) |
| src_ext_o | output | 1 | 1 = external pin is the switching source |
| phase_a_o | output | 1 | Phase enable for converter A |
| phase_b_o | output | 1 | Phase enable for converter B |

## Verification
Some rules are checked on every cycle: an edge reloads the one-shot, a high level or an active detect raises the enable, an expired low run without detect drops it, the phase outputs stay complementary while enabled and silent while disabled, a source change lands at phase A, and the divider holds when it has no tick. Other behaviour needs whole scenarios in the bench. These are the exact length of the clock-detect tail, the shutdown delay counted from the last edge, the half-rate output count under a steady external clock, survival of a short low glitch, and a restart from shutdown by toggling.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;

  // Decide whether a pending source change may be taken this cycle.
  function automatic logic swap_ok(input clk_src_e cur,
                                   input logic     want_ext,
                                   input logic     osc_tick,
                                   input logic     ph_b);
    logic pending;
    pending = (want_ext != (cur == SRC_EXT));
    if (!pending || !osc_tick) return 1'b0;
    // leaving the external source: it has gone quiet, any internal tick
    // entering it: only where the internal divider wraps to phase A
    return (cur == SRC_EXT) ? 1'b1 : ph_b;
  endfunction

  // Saturating run counter step.
  function automatic int unsigned run_step(input logic        clear,
                                           input int unsigned cur,
                                           input int unsigned limit);
    if (clear) return 0;
    return (cur >= limit) ? limit : cur + 1;
  endfunction

endpackage

// File: rtl/ctl_pin_sync.sv
module ctl_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic pin_async,
  output logic lvl_o,
  output logic edge_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_ref or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_async;
      end else begin : g_next
        always_ff @(posedge clk_ref or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[SYNC_STAGES-1];

  assign lvl_o  = chain_q[SYNC_STAGES-1];
  assign edge_o = lvl_o ^ prev_q;
  assign rise_o = lvl_o & ~prev_q;
endmodule

// File: rtl/ctl_oneshot.sv
module ctl_oneshot #(
  parameter int HOLD_CYCLES = 200
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic retrig_i,
  output logic active_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n)             left_q <= '0;
    else if (retrig_i)      left_q <= CW'(HOLD_CYCLES);
    else if (left_q != '0)  left_q <= left_q - CW'(1);

  assign active_o = (left_q != '0);
endmodule

// File: rtl/ctl_enable_ctrl.sv
module ctl_enable_ctrl import ctl_dec_pkg::*; #(
  parameter int LOW_CYCLES = 200
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic det_i,
  output logic en_o,
  output logic expired_o
);
  localparam int LW = $clog2(LOW_CYCLES + 1);
  logic [LW-1:0] run_q;
  logic          en_q;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) run_q <= '0;
    else        run_q <= LW'(run_step(lvl_i, int'(run_q), LOW_CYCLES));

  assign expired_o = (run_q == LW'(LOW_CYCLES));

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n)               en_q <= 1'b0;
    else if (lvl_i || det_i)  en_q <= 1'b1;
    else if (expired_o)       en_q <= 1'b0;

  assign en_o = en_q;
endmodule

// File: rtl/ctl_phase_gen.sv
module ctl_phase_gen import ctl_dec_pkg::*; (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic en_i,
  input  logic det_i,
  input  logic ext_rise_i,
  input  logic osc_tick_i,
  output logic src_ext_o,
  output logic ph_o,
  output logic tick_o,
  output logic swap_o
);
  clk_src_e src_q;
  logic     ph_q;

  assign swap_o = en_i && swap_ok(src_q, det_i, osc_tick_i, ph_q);
  assign tick_o = (src_q == SRC_EXT) ? ext_rise_i : osc_tick_i;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      src_q <= SRC_INT;
      ph_q  <= 1'b0;
    end else if (!en_i) begin
      src_q <= clk_src_e'(det_i);
      ph_q  <= 1'b0;
    end else if (swap_o) begin
      src_q <= clk_src_e'(det_i);
      ph_q  <= 1'b0;
    end else if (tick_o) begin
      ph_q  <= ~ph_q;
    end

  assign src_ext_o = (src_q == SRC_EXT);
  assign ph_o      = ph_q;
endmodule

// File: rtl/ctl_pin_decoder.sv
module ctl_pin_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 200,
  parameter int LOW_CYCLES  = 200
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic ctl_pin,
  input  logic osc_tick,
  output logic enable_o,
  output logic clk_det_o,
  output logic src_ext_o,
  output logic phase_a_o,
  output logic phase_b_o
);
  logic sync_lvl, sync_edge, sync_rise;
  logic det, en, low_expired;
  logic div_ph, div_tick, div_swap;

  ctl_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_ref(clk_ref), .rst_n(rst_n), .pin_async(ctl_pin),
    .lvl_o(sync_lvl), .edge_o(sync_edge), .rise_o(sync_rise)
  );

  ctl_oneshot #(.HOLD_CYCLES(HOLD_CYCLES)) u_shot (
    .clk_ref(clk_ref), .rst_n(rst_n), .retrig_i(sync_edge), .active_o(det)
  );

  ctl_enable_ctrl #(.LOW_CYCLES(LOW_CYCLES)) u_en (
    .clk_ref(clk_ref), .rst_n(rst_n), .lvl_i(sync_lvl), .det_i(det),
    .en_o(en), .expired_o(low_expired)
  );

  ctl_phase_gen u_phase (
    .clk_ref(clk_ref), .rst_n(rst_n), .en_i(en), .det_i(det),
    .ext_rise_i(sync_rise), .osc_tick_i(osc_tick),
    .src_ext_o(src_ext_o), .ph_o(div_ph), .tick_o(div_tick), .swap_o(div_swap)
  );

  assign enable_o  = en;
  assign clk_det_o = det;
  assign phase_a_o = en & ~div_ph;
  assign phase_b_o = en &  div_ph;
endmodule

// File: rtl/ctl_pin_decoder_chk.sv
module ctl_pin_decoder_chk (
  input logic clk_ref,
  input logic rst_n,
  input logic sync_lvl,
  input logic sync_edge,
  input logic det,
  input logic en,
  input logic low_expired,
  input logic src_ext,
  input logic div_ph,
  input logic div_tick,
  input logic div_swap,
  input logic phase_a,
  input logic phase_b
);
  // R2
  high_en_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sync_lvl |=> en);
  // R3
  shutdown_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!sync_lvl && !det && low_expired) |=> !en);
  // R4
  retrig_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sync_edge |=> det);
  // R5
  det_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    det |=> en);
  // R6
  swap_start_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (en && $past(en) && (src_ext != $past(src_ext))) |-> phase_a);
  // R7
  div_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (en && !div_tick && !div_swap) |=> $stable(div_ph));
  // R8
  antiphase_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    en |-> $onehot({phase_a, phase_b}));
  // R9
  idle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !en |-> (!phase_a && !phase_b));
endmodule

bind ctl_pin_decoder ctl_pin_decoder_chk u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .sync_lvl(sync_lvl), .sync_edge(sync_edge),
  .det(det), .en(en), .low_expired(low_expired), .src_ext(src_ext_o),
  .div_ph(div_ph), .div_tick(div_tick), .div_swap(div_swap),
  .phase_a(phase_a_o), .phase_b(phase_b_o)
);

// File: tb/test_ctl_pin_decoder.sv
module test_ctl_pin_decoder;
  localparam int HOLD = 24;
  localparam int LOW  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic osc = 1'b0;
  logic enable_o, clk_det_o, src_ext_o, phase_a_o, phase_b_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctl_pin_decoder #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .LOW_CYCLES(LOW)) i_ctl_pin_decoder (
    .clk_ref(clk), .rst_n(rst_n), .ctl_pin(pin), .osc_tick(osc),
    .enable_o(enable_o), .clk_det_o(clk_det_o), .src_ext_o(src_ext_o),
    .phase_a_o(phase_a_o), .phase_b_o(phase_b_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // internal oscillator: one pulse every 5 cycles
  int osc_cnt = 0;
  always @(negedge clk) begin
    osc_cnt = (osc_cnt == 4) ? 0 : osc_cnt + 1;
    osc = (osc_cnt == 0);
  end

  // reference model: pin history, remaining detect time, low run length
  int hist[$];
  int quiet_left, low_run;
  bit m_en, m_src, m_ph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      quiet_left = 0; low_run = 0;
      m_en = 0; m_src = 0; m_ph = 0;
    end else begin
      int  now_v, old_v;
      bit  det, lost, ext_up, n_en, n_src, n_ph;
      now_v  = hist[1];
      old_v  = hist[2];
      ext_up = (now_v == 1) && (old_v == 0);
      det    = quiet_left > 0;
      lost   = low_run >= LOW;
      n_en   = (now_v == 1 || det) ? 1'b1 : (lost ? 1'b0 : m_en);
      n_src  = m_src;
      n_ph   = m_ph;
      if (!m_en) begin
        n_src = det; n_ph = 0;
      end else if (det != m_src && osc && (m_src || m_ph)) begin
        n_src = det; n_ph = 0;
      end else if (m_src ? ext_up : osc) begin
        n_ph = !m_ph;
      end
      if (now_v != old_v)     quiet_left = HOLD;
      else if (quiet_left > 0) quiet_left--;
      if (now_v == 1) low_run = 0;
      else if (low_run < LOW) low_run++;
      m_en = n_en; m_src = n_src; m_ph = n_ph;
      hist.push_front(int'(pin));
      void'(hist.pop_back());
    end
  end

  // per-cycle comparison, away from the active edge
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2/R3/R5 enable",  int'(enable_o),  int'(m_en));
      check("R4 clk_det",       int'(clk_det_o), int'(quiet_left > 0));
      check("R6/R9 source",     int'(src_ext_o), int'(m_src));
      check("R7/R8 phase_a",    int'(phase_a_o), int'(m_en && !m_ph));
      check("R7/R8 phase_b",    int'(phase_b_o), int'(m_en && m_ph));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle(input int half, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (i % half == 0) pin = ~pin;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 enable",  int'(enable_o),  0);
    check("R1 clk_det", int'(clk_det_o), 0);
    check("R1 source",  int'(src_ext_o), 0);
    check("R1 phase_a", int'(phase_a_o), 0);
    check("R1 phase_b", int'(phase_b_o), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    idle(10);
    check("R9 stays off while low", int'(enable_o), 0);

    // static high: enable, detect tail, internal source
    pin = 1'b1;
    idle(3);
    check("R2 enable after sync", int'(enable_o), 1);
    idle(HOLD + 20);
    check("R4 detect fell at static high", int'(clk_det_o), 0);
    check("R6 internal source", int'(src_ext_o), 0);

    // external clock, half period 3
    toggle(3, 60);
    check("R6 external source", int'(src_ext_o), 1);
    begin
      int rises = 0;
      bit last = phase_b_o;
      for (int i = 0; i < 120; i++) begin
        @(negedge clk);
        if (phase_b_o && !last) rises++;
        last = phase_b_o;
        if (i % 3 == 0) pin = ~pin;
      end
      check("R7 half-rate phase_b pulses", rises, 10);
    end

    // stop at high: detect falls after HOLD, back to internal, still on
    pin = 1'b1;
    idle(HOLD + 15);
    check("R4 detect expired", int'(clk_det_o), 0);
    check("R6 back to internal", int'(src_ext_o), 0);
    check("R5 still enabled", int'(enable_o), 1);

    // short low glitch
    pin = 1'b0;
    idle(LOW - 10);
    pin = 1'b1;
    idle(HOLD + 10);
    check("R3 short low keeps enable", int'(enable_o), 1);

    // fastest toggle: one reference cycle per level
    toggle(1, 40);
    // toggle then static low: shutdown after detect and low run expire
    pin = 1'b0;
    idle(LOW + 5);
    check("R3 shutdown", int'(enable_o), 0);
    check("R9 phases idle", int'(phase_a_o | phase_b_o), 0);

    // restart from shutdown by toggling
    toggle(2, 50);
    check("R5 toggling re-enables", int'(enable_o), 1);
    pin = 1'b0;
    idle(HOLD + LOW + 10);
    check("R3 off again", int'(enable_o), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule